// File: doc/BRIEF.md
# Register Transfer and Exchange Unit

This block is the register-move datapath of a small CPU that works on both 8-bit and 16-bit values. It holds two byte accumulators, a flag byte and three 16-bit registers: two index registers and a stack pointer. It also offers a 16-bit view of the two accumulators joined together, with the first accumulator as the high byte. Each clock cycle it can carry out one register-to-register operation. A source select code, a destination select code and a 2-bit operation code pick the operation, and the result appears after the next rising clock edge.

Four operations are available: a plain move, an exchange, an explicit sign-widening, and a byte copy between the two accumulators that updates the flags. A move or exchange between registers of different widths follows a fixed conversion rule. A move sign-extends a byte going into a 16-bit register. An exchange zero-extends it. In both, the byte side receives only the low byte of the 16-bit register. A separate load port writes a value into any register directly. Upstream logic uses it to deliver operands fetched from memory. Select codes and operations that have no meaning are rejected: a flag reports them in the same cycle and no register changes.

Top module: `rxu_xfer_unit`

## Requirements
- R1: While reset is active, and directly after it, every register and every output reads zero, including the flag byte.
- R2: The select codes are 0 = accumulator A, 1 = accumulator B, 2 = flag byte (8-bit), 3 = joined pair D = A:B with A as the high byte, 4 = index X, 5 = index Y, 6 = stack pointer (16-bit). A load writes the full value into a 16-bit target. It writes the low byte of the load data into an 8-bit target. A load into D updates both A and B.
- R3: Operation 0 (move) copies source to destination. Same-width copies are exact. A byte copied into a 16-bit register is sign-extended. A 16-bit source copied into a byte register gives its low byte. The flag byte is left unchanged unless it is the destination.
- R4: Operation 1 (exchange) swaps two registers. When the widths differ, the 16-bit register receives 0x00 above the byte, and the byte register receives the low byte of the 16-bit register. An exchange of a register with itself changes nothing.
- R5: When an exchange pairs D with A or B, the value written to that accumulator overrides the corresponding half of the value written to D.
- R6: Operation 2 (widen) writes the sign-extended value of an 8-bit source into a 16-bit destination. A 16-bit source or an 8-bit destination is illegal.
- R7: Operation 3 (flagged copy) is legal only from A to B or from B to A. It copies the byte, sets flag bit 3 to the sign bit of the byte and flag bit 2 when the byte is zero, clears flag bit 1, and keeps the other flag bits.
- R8: Code 7 in the source or destination of an operation, an illegal pairing, or code 7 on a load raises illegal_o in the same cycle. In that case no register changes.
- R9: When an operation and a load are requested in the same cycle, the operation takes effect and the load is ignored. With neither requested, all registers hold.
- R10: An accepted operation or load changes the outputs only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_en_i | input | 1 | Request an operation this cycle |
| op_i | input | 2 | Operation: 0 move, 1 exchange, 2 widen, 3 flagged copy |
| src_i | input | 3 | Source register select |
| dst_i | input | 3 | Destination register select |
| ld_en_i | input | 1 | Request a direct load this cycle |
| ld_sel_i | input | 3 | Load target select |
| ld_data_i | input | 16 | Load value |
| a_o | output | 8 | Accumulator A |
| b_o | output | 8 | Accumulator B |
| d_o | output | 16 | Joined pair A:B |
| ccr_o | output | 8 | Flag byte |
| x_o | output | 16 | Index X |
| y_o | output | 16 | Index Y |
| sp_o | output | 16 | Stack pointer |
| illegal_o | output | 1 | Current request rejected |

## Verification
The bench builds the block with its default 8-bit byte width and flag positions 3, 2 and 1. With these values, all 256 combinations of operation, source code and destination code, including the unused code 7, can be swept in full. Before each combination the bench loads four different register patterns. These patterns alternate the byte sign bit and include zero accumulators, so it sees every width pairing, both extension rules, the D-versus-accumulator overlap and both flag outcomes. Expected register states come from a behavioural model kept in the bench.

// File: rtl/rxu_pkg.sv
package rxu_pkg;

   typedef enum logic [1:0] {
      RXU_OP_MOVE  = 2'd0,
      RXU_OP_SWAP  = 2'd1,
      RXU_OP_WIDEN = 2'd2,
      RXU_OP_MOVEF = 2'd3
   } rxu_op_e;

   localparam int unsigned RXU_SEL_W = 3;
   localparam int unsigned RXU_NSEL  = 1 << RXU_SEL_W;

   localparam logic [RXU_SEL_W-1:0] RXU_SEL_A  = 3'd0;
   localparam logic [RXU_SEL_W-1:0] RXU_SEL_B  = 3'd1;
   localparam logic [RXU_SEL_W-1:0] RXU_SEL_CC = 3'd2;
   localparam logic [RXU_SEL_W-1:0] RXU_SEL_D  = 3'd3;
   localparam logic [RXU_SEL_W-1:0] RXU_SEL_X  = 3'd4;
   localparam logic [RXU_SEL_W-1:0] RXU_SEL_Y  = 3'd5;
   localparam logic [RXU_SEL_W-1:0] RXU_SEL_SP = 3'd6;

   function automatic logic rxu_sel_ok(input logic [RXU_SEL_W-1:0] sel);
      return sel <= RXU_SEL_SP;
   endfunction

   function automatic logic rxu_sel_wide(input logic [RXU_SEL_W-1:0] sel);
      return (sel == RXU_SEL_D) || (sel == RXU_SEL_X) ||
             (sel == RXU_SEL_Y) || (sel == RXU_SEL_SP);
   endfunction

endpackage

// File: rtl/rxu_read_port.sv
module rxu_read_port
   import rxu_pkg::*;
#(
   parameter int unsigned BYTE_W = 8
) (
   input  logic [RXU_SEL_W-1:0] sel_i,
   input  logic [BYTE_W-1:0]    a_i,
   input  logic [BYTE_W-1:0]    b_i,
   input  logic [BYTE_W-1:0]    cc_i,
   input  logic [2*BYTE_W-1:0]  x_i,
   input  logic [2*BYTE_W-1:0]  y_i,
   input  logic [2*BYTE_W-1:0]  sp_i,
   output logic [2*BYTE_W-1:0]  val_o,
   output logic                 wide_o,
   output logic                 ok_o
);

   localparam int unsigned WORD_W = 2 * BYTE_W;

   logic [WORD_W-1:0] bank [RXU_NSEL];

   for (genvar g = 0; g < RXU_NSEL; g++) begin : g_bank
      if (g == int'(RXU_SEL_A)) begin : g_a
         assign bank[g] = {{BYTE_W{1'b0}}, a_i};
      end else if (g == int'(RXU_SEL_B)) begin : g_b
         assign bank[g] = {{BYTE_W{1'b0}}, b_i};
      end else if (g == int'(RXU_SEL_CC)) begin : g_cc
         assign bank[g] = {{BYTE_W{1'b0}}, cc_i};
      end else if (g == int'(RXU_SEL_D)) begin : g_d
         assign bank[g] = {a_i, b_i};
      end else if (g == int'(RXU_SEL_X)) begin : g_x
         assign bank[g] = x_i;
      end else if (g == int'(RXU_SEL_Y)) begin : g_y
         assign bank[g] = y_i;
      end else if (g == int'(RXU_SEL_SP)) begin : g_sp
         assign bank[g] = sp_i;
      end else begin : g_none
         assign bank[g] = '0;
      end
   end

   assign ok_o   = rxu_sel_ok(sel_i);
   assign wide_o = rxu_sel_wide(sel_i);
   assign val_o  = bank[sel_i];

endmodule

// File: rtl/rxu_convert.sv
module rxu_convert
   import rxu_pkg::*;
#(
   parameter int unsigned BYTE_W = 8
) (
   input  rxu_op_e              op_i,
   input  logic [RXU_SEL_W-1:0] src_i,
   input  logic [RXU_SEL_W-1:0] dst_i,
   input  logic [2*BYTE_W-1:0]  src_val_i,
   input  logic                 src_wide_i,
   input  logic                 src_ok_i,
   input  logic [2*BYTE_W-1:0]  dst_val_i,
   input  logic                 dst_wide_i,
   input  logic                 dst_ok_i,
   output logic                 w0_en_o,
   output logic [RXU_SEL_W-1:0] w0_sel_o,
   output logic [2*BYTE_W-1:0]  w0_data_o,
   output logic                 w1_en_o,
   output logic [RXU_SEL_W-1:0] w1_sel_o,
   output logic [2*BYTE_W-1:0]  w1_data_o,
   output logic                 flag_en_o,
   output logic                 flag_n_o,
   output logic                 flag_z_o,
   output logic                 bad_o
);

   localparam int unsigned WORD_W = 2 * BYTE_W;

   function automatic logic [WORD_W-1:0] fit(input logic [WORD_W-1:0] v,
                                             input logic from_wide,
                                             input logic to_wide,
                                             input logic sign_fill);
      logic [BYTE_W-1:0] lo;
      lo = v[BYTE_W-1:0];
      if (to_wide && !from_wide) begin
         return {{BYTE_W{sign_fill & lo[BYTE_W-1]}}, lo};
      end
      return v;
   endfunction

   logic pair_ab;
   logic widen_bad;

   assign pair_ab   = ((src_i == RXU_SEL_A) && (dst_i == RXU_SEL_B)) ||
                      ((src_i == RXU_SEL_B) && (dst_i == RXU_SEL_A));
   assign widen_bad = src_wide_i || !dst_wide_i;

   always_comb begin
      bad_o = !src_ok_i || !dst_ok_i;
      unique case (op_i)
         RXU_OP_WIDEN: bad_o = bad_o || widen_bad;
         RXU_OP_MOVEF: bad_o = bad_o || !pair_ab;
         default:      ;
      endcase
   end

   assign w0_en_o   = !bad_o;
   assign w0_sel_o  = dst_i;
   assign w0_data_o = fit(src_val_i, src_wide_i, dst_wide_i, op_i != RXU_OP_SWAP);

   assign w1_en_o   = !bad_o && (op_i == RXU_OP_SWAP) && (src_i != dst_i);
   assign w1_sel_o  = src_i;
   assign w1_data_o = fit(dst_val_i, dst_wide_i, src_wide_i, 1'b0);

   assign flag_en_o = !bad_o && (op_i == RXU_OP_MOVEF);
   assign flag_n_o  = src_val_i[BYTE_W-1];
   assign flag_z_o  = (src_val_i[BYTE_W-1:0] == '0);

endmodule

// File: rtl/rxu_regbank.sv
module rxu_regbank
   import rxu_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned N_BIT  = 3,
   parameter int unsigned Z_BIT  = 2,
   parameter int unsigned V_BIT  = 1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 w0_en_i,
   input  logic [RXU_SEL_W-1:0] w0_sel_i,
   input  logic [2*BYTE_W-1:0]  w0_data_i,
   input  logic                 w1_en_i,
   input  logic [RXU_SEL_W-1:0] w1_sel_i,
   input  logic [2*BYTE_W-1:0]  w1_data_i,
   input  logic                 flag_en_i,
   input  logic                 flag_n_i,
   input  logic                 flag_z_i,
   output logic [BYTE_W-1:0]    a_o,
   output logic [BYTE_W-1:0]    b_o,
   output logic [BYTE_W-1:0]    cc_o,
   output logic [2*BYTE_W-1:0]  x_o,
   output logic [2*BYTE_W-1:0]  y_o,
   output logic [2*BYTE_W-1:0]  sp_o
);

   localparam int unsigned WORD_W = 2 * BYTE_W;
   localparam int unsigned NPORT  = 2;

   logic [NPORT-1:0]                wen;
   logic [NPORT-1:0][RXU_SEL_W-1:0] wsel;
   logic [NPORT-1:0][WORD_W-1:0]    wdat;

   assign wen  = {w1_en_i, w0_en_i};
   assign wsel = {w1_sel_i, w0_sel_i};
   assign wdat = {w1_data_i, w0_data_i};

   logic [BYTE_W-1:0] a_q, b_q, cc_q, a_d, b_d, cc_d;
   logic [WORD_W-1:0] x_q, y_q, sp_q, x_d, y_d, sp_d;

   always_comb begin
      a_d  = a_q;
      b_d  = b_q;
      cc_d = cc_q;
      x_d  = x_q;
      y_d  = y_q;
      sp_d = sp_q;
      // 16-bit targets first so that byte targets override the D halves
      for (int p = 0; p < NPORT; p++) begin
         if (wen[p] && rxu_sel_wide(wsel[p])) begin
            unique case (wsel[p])
               RXU_SEL_D: begin
                  a_d = wdat[p][WORD_W-1:BYTE_W];
                  b_d = wdat[p][BYTE_W-1:0];
               end
               RXU_SEL_X:  x_d  = wdat[p];
               RXU_SEL_Y:  y_d  = wdat[p];
               default:    sp_d = wdat[p];
            endcase
         end
      end
      for (int p = 0; p < NPORT; p++) begin
         if (wen[p] && !rxu_sel_wide(wsel[p])) begin
            unique case (wsel[p])
               RXU_SEL_A:  a_d  = wdat[p][BYTE_W-1:0];
               RXU_SEL_B:  b_d  = wdat[p][BYTE_W-1:0];
               RXU_SEL_CC: cc_d = wdat[p][BYTE_W-1:0];
               default:    ;
            endcase
         end
      end
      if (flag_en_i) begin
         cc_d[N_BIT] = flag_n_i;
         cc_d[Z_BIT] = flag_z_i;
         cc_d[V_BIT] = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         a_q  <= '0;
         b_q  <= '0;
         cc_q <= '0;
         x_q  <= '0;
         y_q  <= '0;
         sp_q <= '0;
      end else begin
         a_q  <= a_d;
         b_q  <= b_d;
         cc_q <= cc_d;
         x_q  <= x_d;
         y_q  <= y_d;
         sp_q <= sp_d;
      end
   end

   assign a_o  = a_q;
   assign b_o  = b_q;
   assign cc_o = cc_q;
   assign x_o  = x_q;
   assign y_o  = y_q;
   assign sp_o = sp_q;

   AST_NO_PORT_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (w0_en_i && w1_en_i) |-> (w0_sel_i != w1_sel_i)) // R4
      else $error("two write ports target one register");

endmodule

// File: rtl/rxu_xfer_unit.sv
module rxu_xfer_unit
   import rxu_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned N_BIT  = 3,
   parameter int unsigned Z_BIT  = 2,
   parameter int unsigned V_BIT  = 1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                op_en_i,
   input  logic [1:0]          op_i,
   input  logic [2:0]          src_i,
   input  logic [2:0]          dst_i,
   input  logic                ld_en_i,
   input  logic [2:0]          ld_sel_i,
   input  logic [2*BYTE_W-1:0] ld_data_i,
   output logic [BYTE_W-1:0]   a_o,
   output logic [BYTE_W-1:0]   b_o,
   output logic [2*BYTE_W-1:0] d_o,
   output logic [BYTE_W-1:0]   ccr_o,
   output logic [2*BYTE_W-1:0] x_o,
   output logic [2*BYTE_W-1:0] y_o,
   output logic [2*BYTE_W-1:0] sp_o,
   output logic                illegal_o
);

   localparam int unsigned WORD_W = 2 * BYTE_W;

   if (BYTE_W < 2) begin : g_chk_width
      $error("BYTE_W must be at least 2");
   end
   if (N_BIT >= BYTE_W || Z_BIT >= BYTE_W || V_BIT >= BYTE_W) begin : g_chk_pos
      $error("flag positions must lie inside the flag byte");
   end
   if (N_BIT == Z_BIT || N_BIT == V_BIT || Z_BIT == V_BIT) begin : g_chk_dist
      $error("flag positions must be distinct");
   end

   rxu_op_e           op;
   logic [WORD_W-1:0] src_val, dst_val;
   logic              src_wide, dst_wide, src_ok, dst_ok;

   assign op = rxu_op_e'(op_i);

   rxu_read_port #(.BYTE_W(BYTE_W)) u_rd_src (
      .sel_i(src_i), .a_i(a_o), .b_i(b_o), .cc_i(ccr_o),
      .x_i(x_o), .y_i(y_o), .sp_i(sp_o),
      .val_o(src_val), .wide_o(src_wide), .ok_o(src_ok)
   );

   rxu_read_port #(.BYTE_W(BYTE_W)) u_rd_dst (
      .sel_i(dst_i), .a_i(a_o), .b_i(b_o), .cc_i(ccr_o),
      .x_i(x_o), .y_i(y_o), .sp_i(sp_o),
      .val_o(dst_val), .wide_o(dst_wide), .ok_o(dst_ok)
   );

   logic                 c0_en, c1_en, cf_en, cf_n, cf_z, c_bad;
   logic [RXU_SEL_W-1:0] c0_sel, c1_sel;
   logic [WORD_W-1:0]    c0_data, c1_data;

   rxu_convert #(.BYTE_W(BYTE_W)) u_conv (
      .op_i(op), .src_i(src_i), .dst_i(dst_i),
      .src_val_i(src_val), .src_wide_i(src_wide), .src_ok_i(src_ok),
      .dst_val_i(dst_val), .dst_wide_i(dst_wide), .dst_ok_i(dst_ok),
      .w0_en_o(c0_en), .w0_sel_o(c0_sel), .w0_data_o(c0_data),
      .w1_en_o(c1_en), .w1_sel_o(c1_sel), .w1_data_o(c1_data),
      .flag_en_o(cf_en), .flag_n_o(cf_n), .flag_z_o(cf_z), .bad_o(c_bad)
   );

   // port 0 carries either the operation result or the load; operation wins
   logic                 ld_take, ld_bad;
   logic                 p0_en, p1_en, pf_en;
   logic [RXU_SEL_W-1:0] p0_sel;
   logic [WORD_W-1:0]    p0_data;

   assign ld_take = ld_en_i && !op_en_i;
   assign ld_bad  = ld_take && !rxu_sel_ok(ld_sel_i);

   assign p0_en   = op_en_i ? c0_en : (ld_take && !ld_bad);
   assign p0_sel  = op_en_i ? c0_sel : ld_sel_i;
   assign p0_data = op_en_i ? c0_data : ld_data_i;
   assign p1_en   = op_en_i && c1_en;
   assign pf_en   = op_en_i && cf_en;

   assign illegal_o = (op_en_i && c_bad) || ld_bad;

   rxu_regbank #(.BYTE_W(BYTE_W), .N_BIT(N_BIT), .Z_BIT(Z_BIT), .V_BIT(V_BIT)) u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .w0_en_i(p0_en), .w0_sel_i(p0_sel), .w0_data_i(p0_data),
      .w1_en_i(p1_en), .w1_sel_i(c1_sel), .w1_data_i(c1_data),
      .flag_en_i(pf_en), .flag_n_i(cf_n), .flag_z_i(cf_z),
      .a_o(a_o), .b_o(b_o), .cc_o(ccr_o), .x_o(x_o), .y_o(y_o), .sp_o(sp_o)
   );

   assign d_o = {a_o, b_o};

   AST_ILLEGAL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      illegal_o |=> ($stable(d_o) && $stable(ccr_o) && $stable(x_o) &&
                     $stable(y_o) && $stable(sp_o))) // R8
      else $error("rejected request changed a register");

   AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!op_en_i && !ld_en_i) |=> ($stable(d_o) && $stable(ccr_o) && $stable(x_o) &&
                                  $stable(y_o) && $stable(sp_o))) // R9
      else $error("registers moved while idle");

   AST_MOVE_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_en_i && op_i == RXU_OP_MOVE && dst_i != RXU_SEL_CC && !illegal_o)
      |=> $stable(ccr_o)) // R3
      else $error("move altered the flag byte");

   AST_SELF_SWAP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_en_i && op_i == RXU_OP_SWAP && src_i == dst_i && !illegal_o)
      |=> ($stable(d_o) && $stable(ccr_o) && $stable(x_o) &&
           $stable(y_o) && $stable(sp_o))) // R4
      else $error("self exchange changed a register");

   AST_WIDEN_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_en_i && op_i == RXU_OP_WIDEN && src_i == RXU_SEL_A && dst_i == RXU_SEL_X)
      |=> (x_o == {{BYTE_W{$past(a_o[BYTE_W-1])}}, $past(a_o)})) // R6
      else $error("widen did not sign-extend");

   AST_FLAGCOPY_CLEARS_V: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_en_i && op_i == RXU_OP_MOVEF && !illegal_o) |=> !ccr_o[V_BIT]) // R7
      else $error("flagged copy left overflow flag set");

endmodule

// File: tb/rxu_xfer_unit_tb.sv
module rxu_xfer_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_en = 1'b0;
   logic [1:0]  op = '0;
   logic [2:0]  src = '0, dst = '0;
   logic        ld_en = 1'b0;
   logic [2:0]  ld_sel = '0;
   logic [15:0] ld_data = '0;
   logic [7:0]  a, b, ccr;
   logic [15:0] d, x, y, sp;
   logic        illegal;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   rxu_xfer_unit u_dut (
      .clk_i(clk), .rst_ni(rst_n), .op_en_i(op_en), .op_i(op),
      .src_i(src), .dst_i(dst), .ld_en_i(ld_en), .ld_sel_i(ld_sel),
      .ld_data_i(ld_data), .a_o(a), .b_o(b), .d_o(d), .ccr_o(ccr),
      .x_o(x), .y_o(y), .sp_o(sp), .illegal_o(illegal)
   );

   // behavioural model
   logic [7:0]  ma, mb, mc;
   logic [15:0] mx, my, ms;

   function automatic logic wide(input logic [2:0] s);
      return (s >= 3'd3) && (s <= 3'd6);
   endfunction

   function automatic logic [15:0] mget(input logic [2:0] s);
      case (s)
         3'd0: return {8'h00, ma};
         3'd1: return {8'h00, mb};
         3'd2: return {8'h00, mc};
         3'd3: return {ma, mb};
         3'd4: return mx;
         3'd5: return my;
         3'd6: return ms;
         default: return 16'h0000;
      endcase
   endfunction

   task automatic put16(input logic [2:0] s, input logic [15:0] v);
      case (s)
         3'd3: begin ma = v[15:8]; mb = v[7:0]; end
         3'd4: mx = v;
         3'd5: my = v;
         3'd6: ms = v;
         default: ;
      endcase
   endtask

   task automatic put8(input logic [2:0] s, input logic [7:0] v);
      case (s)
         3'd0: ma = v;
         3'd1: mb = v;
         3'd2: mc = v;
         default: ;
      endcase
   endtask

   task automatic model_op(input logic [1:0] o, input logic [2:0] s, input logic [2:0] t,
                           output logic ill);
      logic [15:0] sv, tv, nt, ns;
      sv = mget(s);
      tv = mget(t);
      ill = (s == 3'd7) || (t == 3'd7);
      if (o == 2'd2 && (wide(s) || !wide(t))) ill = 1'b1;
      if (o == 2'd3 && !((s == 3'd0 && t == 3'd1) || (s == 3'd1 && t == 3'd0))) ill = 1'b1;
      if (ill) return;
      case (o)
         2'd0, 2'd2: begin
            if (wide(t)) put16(t, wide(s) ? sv : {{8{sv[7]}}, sv[7:0]});
            else         put8(t, sv[7:0]);
         end
         2'd1: if (s != t) begin
            nt = (wide(t) && !wide(s)) ? {8'h00, sv[7:0]} : sv;
            ns = (wide(s) && !wide(t)) ? {8'h00, tv[7:0]} : tv;
            if (wide(t)) put16(t, nt);
            if (wide(s)) put16(s, ns);
            if (!wide(t)) put8(t, nt[7:0]);
            if (!wide(s)) put8(s, ns[7:0]);
         end
         default: begin
            put8(t, sv[7:0]);
            mc[3] = sv[7];
            mc[2] = (sv[7:0] == 8'h00);
            mc[1] = 1'b0;
         end
      endcase
   endtask

   task automatic check_state(input string req);
      logic [87:0] act, exp;
      act = {a, b, d, ccr, x, y, sp};
      exp = {ma, mb, ma, mb, mc, mx, my, ms};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s state actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_bit(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s illegal actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic do_load(input logic [2:0] s, input logic [15:0] v);
      @(negedge clk);
      ld_en = 1'b1; ld_sel = s; ld_data = v;
      if (s != 3'd7) begin
         if (wide(s)) put16(s, v);
         else         put8(s, v[7:0]);
      end
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   function automatic logic [15:0] pat(input int k, input int i);
      logic [15:0] v;
      if (k == 3 && i < 2) return 16'h0000;
      v = 16'h5A3C ^ 16'(k * 16'h1111 + i * 16'h0F0F);
      v[7] = ((k + i) % 2) == 1;
      return v;
   endfunction

   initial begin
      #(4 * 190000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic ill;
      string rq;
      ma = '0; mb = '0; mc = '0; mx = '0; my = '0; ms = '0;
      repeat (3) @(negedge clk);
      check_state("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1");

      for (int o = 0; o < 4; o++) begin
         for (int s = 0; s < 8; s++) begin
            for (int t = 0; t < 8; t++) begin
               for (int k = 0; k < 4; k++) begin
                  for (int i = 0; i < 7; i++) begin
                     if (i != 3) do_load(3'(i), pat(k, i));
                  end
                  check_state("R2");
                  case (o)
                     0: rq = "R3";
                     1: rq = (s == 3 || t == 3) ? "R5" : "R4";
                     2: rq = "R6";
                     default: rq = "R7";
                  endcase
                  op_en = 1'b1; op = 2'(o); src = 3'(s); dst = 3'(t);
                  model_op(2'(o), 3'(s), 3'(t), ill);
                  #1;
                  check_bit(ill ? "R8" : rq, illegal, ill);
                  @(negedge clk);
                  op_en = 1'b0;
                  check_state(ill ? "R8" : rq);
               end
            end
         end
      end

      // R9: load and operation together, operation wins
      do_load(3'd4, 16'h1234);
      do_load(3'd0, 16'h0081);
      @(negedge clk);
      op_en = 1'b1; op = 2'd0; src = 3'd0; dst = 3'd1;
      ld_en = 1'b1; ld_sel = 3'd4; ld_data = 16'hBEEF;
      model_op(2'd0, 3'd0, 3'd1, ill);
      @(negedge clk);
      op_en = 1'b0; ld_en = 1'b0;
      check_state("R9");

      // R9: idle holds
      repeat (3) @(negedge clk);
      check_state("R9");

      // R8: load with unused code
      @(negedge clk);
      ld_en = 1'b1; ld_sel = 3'd7; ld_data = 16'hFFFF;
      #1;
      check_bit("R8", illegal, 1'b1);
      @(negedge clk);
      ld_en = 1'b0;
      check_state("R8");

      // R10: nothing visible before the edge
      op_en = 1'b1; op = 2'd1; src = 3'd4; dst = 3'd6;
      #1;
      check_state("R10");
      model_op(2'd1, 3'd4, 3'd6, ill);
      @(negedge clk);
      op_en = 1'b0;
      check_state("R10");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule